// File: doc/BRIEF.md
# Ethernet Transmit Retry Controller

This block decides, frame by frame, whether a transmission that met a collision is tried again and how long the retry waits. A frame request starts the first attempt. The controller counts the attempts. After each collision it waits for a random number of slot times, then starts the next attempt. When the attempt limit is reached, or when single-attempt mode forbids a retry, it closes the frame with a retry error.

Two test features are included. A single-attempt mode gives every frame exactly one try. A forced-collision mode treats every attempt of a frame as having collided, which drives the frame through the full attempt sequence. The forced-collision mode acts only while internal loopback is selected. An optional gentler backoff can be switched on. Reset and the stop command switch it off again.

The interface is plain control. A frame request is taken only while the block is idle and is dropped otherwise, so no back-pressure exists. The surrounding logic reports the end of each attempt with `attempt_end` or `collision`.

Top module: `tx_retry_ctrl`

## Requirements
- R1: After reset `busy`, `tx_go`, `done`, `retry_err` and `mod_bo_on` are all low.
- R2: In the cycle after `frame_req` is seen while idle, `tx_go` pulses for one cycle and `busy` goes high. A `frame_req` that arrives while `busy` is high is dropped.
- R3: An attempt that ends with `attempt_end` and without a collision finishes the frame. `done` pulses with `retry_err` low and `busy` falls.
- R4: After the n-th collision of a frame, the next `tx_go` follows after w consumed slot ticks, where 0 <= w <= 2^min(n,10)-1.
- R5: A frame gets at most 16 attempts. A collision on the 16th attempt gives `done` with `retry_err` high, and no further `tx_go` follows.
- R6: When `cfg_no_retry` is set, one attempt is made. A collision on it gives `done` with `retry_err` high.
- R7: When `cfg_force_coll` and `cfg_int_loop` are both set, every `attempt_end` of that frame counts as a collision. The frame gets 16 attempts and then ends with `retry_err`.
- R8: When `cfg_force_coll` is set without `cfg_int_loop`, it is ignored and `attempt_end` completes the frame normally.
- R9: `mbo_set` turns `mod_bo_on` on. While it is on, the first 3 collisions of a frame use the exponent min(n,2) instead of min(n,10).
- R10: `stop` aborts any frame without a `done`. In the next cycle `busy` and `mod_bo_on` are low.
- R11: `done` lasts one cycle, and `retry_err` is high only together with `done`.
- R12: The mode inputs are sampled when a frame is accepted. Changing them during the frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop | input | 1 | Abort the frame and clear the gentler-backoff enable |
| mbo_set | input | 1 | Turn on the gentler backoff |
| cfg_no_retry | input | 1 | Single-attempt mode |
| cfg_force_coll | input | 1 | Treat every attempt as collided (test) |
| cfg_int_loop | input | 1 | Internal loopback selected |
| frame_req | input | 1 | Start a frame (taken only when idle) |
| collision | input | 1 | Collision on the current attempt |
| attempt_end | input | 1 | Current attempt finished |
| slot_tick | input | 1 | One slot time has elapsed |
| tx_go | output | 1 | Start an attempt now (one-cycle strobe) |
| done | output | 1 | Frame finished (one-cycle strobe) |
| retry_err | output | 1 | Frame gave up; valid with `done` |
| busy | output | 1 | A frame is in progress |
| mod_bo_on | output | 1 | Gentler backoff is enabled |

## Verification
The assertions assume that `collision` and `attempt_end` are single-cycle pulses. They also assume that these pulses arrive only while an attempt is on the medium, after its `tx_go` and before the next one. The stimulus meets this by driving one such pulse per observed `tx_go`, and no pulse at any other time. The mode inputs may change only between frames, except in the one test for R12 that changes them on purpose. `slot_tick` is held high, so every cycle of a backoff consumes one slot. This lets the bench measure each wait exactly, in cycles.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT} rc_state_t;

  // backoff exponent for the n-th collision of a frame
  function automatic int unsigned bo_exp(input int unsigned n, input logic gentle,
                                         input int unsigned lim, input int unsigned cap,
                                         input int unsigned span);
    int unsigned k;
    k = (n < lim) ? n : lim;
    if (gentle && n <= span) k = (n < cap) ? n : cap;
    return k;
  endfunction
endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] q
);
  logic fb;
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[14:0], fb};
  end

  // the shift register never locks up in the all-zero state
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/rc_bo_timer.sv
module rc_bo_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == 0);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl #(
  parameter int          MAX_ATT  = 16,
  parameter int          EXP_LIM  = 10,
  parameter int          MOD_CAP  = 2,
  parameter int          MOD_SPAN = 3,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic mbo_set,
  input  logic cfg_no_retry,
  input  logic cfg_force_coll,
  input  logic cfg_int_loop,
  input  logic frame_req,
  input  logic collision,
  input  logic attempt_end,
  input  logic slot_tick,
  output logic tx_go,
  output logic done,
  output logic retry_err,
  output logic busy,
  output logic mod_bo_on
);
  import rc_pkg::*;

  localparam int CNT_W = EXP_LIM;
  localparam int ATT_W = $clog2(MAX_ATT + 1);

  rc_state_t        st;
  logic [ATT_W-1:0] att;
  logic             single_q, force_q;
  logic [15:0]      rnd;
  logic             hit, last, ld, expired;
  logic [CNT_W:0]   span_one;
  logic [CNT_W-1:0] mask, ld_val;
  int unsigned      k;

  assign hit  = collision | (attempt_end & force_q);
  assign last = single_q | (att == ATT_W'(MAX_ATT));
  assign k    = bo_exp(32'(att), mod_bo_on, EXP_LIM, MOD_CAP, MOD_SPAN);
  assign span_one = (CNT_W+1)'(1) << k;
  assign mask     = CNT_W'(span_one - 1'b1);
  assign ld_val   = rnd[CNT_W-1:0] & mask;
  assign ld       = (st == ST_TX) && hit && !last && !stop;
  assign busy     = (st != ST_IDLE);

  rc_lfsr #(.SEED(SEED)) u_prng (.clk(clk), .rst_n(rst_n), .q(rnd));

  rc_bo_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .tick(slot_tick), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      att       <= '0;
      single_q  <= 1'b0;
      force_q   <= 1'b0;
      mod_bo_on <= 1'b0;
      tx_go     <= 1'b0;
      done      <= 1'b0;
      retry_err <= 1'b0;
    end else begin
      tx_go     <= 1'b0;
      done      <= 1'b0;
      retry_err <= 1'b0;
      if (mbo_set) mod_bo_on <= 1'b1;
      if (stop) begin
        st        <= ST_IDLE;
        mod_bo_on <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: if (frame_req) begin
            st       <= ST_TX;
            tx_go    <= 1'b1;
            att      <= ATT_W'(1);
            single_q <= cfg_no_retry;
            force_q  <= cfg_force_coll & cfg_int_loop;
          end
          ST_TX: begin
            if (hit) begin
              if (last) begin
                st        <= ST_IDLE;
                done      <= 1'b1;
                retry_err <= 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end else if (attempt_end) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
          ST_WAIT: if (expired) begin
            st    <= ST_TX;
            tx_go <= 1'b1;
            att   <= att + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_err |-> done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  att_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att <= ATT_W'(MAX_ATT));
  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !mod_bo_on && !done));
  // R2
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> busy);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop && (st == ST_WAIT)) |=> busy);
endmodule

// File: tb/tx_retry_ctrl_test.sv
module tx_retry_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 0, mbo_set = 0, cfg_no_retry = 0, cfg_force_coll = 0, cfg_int_loop = 0;
  logic frame_req = 0, collision = 0, attempt_end = 0, slot_tick = 1;
  logic tx_go, done, retry_err, busy, mod_bo_on;

  int n_chk = 0, n_fail = 0;
  bit gentle = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tx_retry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stop(stop), .mbo_set(mbo_set),
    .cfg_no_retry(cfg_no_retry), .cfg_force_coll(cfg_force_coll),
    .cfg_int_loop(cfg_int_loop), .frame_req(frame_req), .collision(collision),
    .attempt_end(attempt_end), .slot_tick(slot_tick), .tx_go(tx_go), .done(done),
    .retry_err(retry_err), .busy(busy), .mod_bo_on(mod_bo_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wait_lim(input int n);
    int k;
    k = (n < 10) ? n : 10;
    if (gentle && n <= 3) k = (n < 2) ? n : 2;
    return (1 << k) - 1;
  endfunction

  // one frame: ncoll collisions then success; ends_only drives attempt_end every time
  task automatic run_frame(input int ncoll, input bit ends_only, input bit extra_req,
                           input bit flip_mode, output int gos, output bit err);
    bit fin = 0;
    int t, lows;
    gos = 0; err = 0;
    frame_req = 1;
    @(negedge clk); frame_req = 0;
    while (!fin) begin
      t = 0;
      while (!tx_go && t < 3000) begin @(negedge clk); t++; end
      if (!tx_go) begin chk(0, "R2 tx_go timeout", 0, 1); break; end
      gos++;
      if (gos == 1) chk(busy == 1, "R2 busy", busy, 1);
      if (extra_req && gos == 1) frame_req = 1;
      if (flip_mode && gos == 1) cfg_no_retry = 1;
      if (ends_only || gos > ncoll) attempt_end = 1; else collision = 1;
      @(negedge clk); collision = 0; attempt_end = 0; frame_req = 0;
      if (done) begin
        err = retry_err;
        fin = 1;
      end else begin
        if (!busy) begin chk(0, "R10 unexpected idle", 0, 1); break; end
        lows = 1;
        t = 0;
        while (t < 3000) begin
          @(negedge clk); t++;
          if (tx_go) break;
          lows++;
        end
        // R4 bound on the wait after collision number gos
        chk(lows - 1 <= wait_lim(gos), "R4 backoff bound", lows - 1, wait_lim(gos));
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle", done, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!tx_go, "R5 no go after done", tx_go, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int gos;
    bit err;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !tx_go && !done && !retry_err && !mod_bo_on, "R1 reset idle", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_go, "R1 after release", tx_go, 0);

    // R3 / R4: sweep collision counts
    for (int n = 0; n <= 6; n++) begin
      run_frame(n, 0, 0, 0, gos, err);
      chk(gos == n + 1, "R4 attempt count", gos, n + 1);
      chk(err == 0, "R3 success no error", err, 0);
    end
    // R5 boundary: 15 collisions succeed, 16 fail
    run_frame(15, 0, 0, 0, gos, err);
    chk(gos == 16 && err == 0, "R5 sixteenth ok", gos, 16);
    run_frame(16, 0, 0, 0, gos, err);
    chk(gos == 16, "R5 attempt limit", gos, 16);
    chk(err == 1, "R5 retry_err", err, 1);
    // R2 request while busy is dropped
    run_frame(0, 0, 1, 0, gos, err);
    chk(gos == 1 && err == 0, "R2 busy req dropped", gos, 1);
    // R6 single attempt
    cfg_no_retry = 1;
    run_frame(1, 0, 0, 0, gos, err);
    chk(gos == 1 && err == 1, "R6 single attempt error", gos, 1);
    run_frame(0, 0, 0, 0, gos, err);
    chk(gos == 1 && err == 0, "R6 single attempt ok", err, 0);
    cfg_no_retry = 0;
    // R12 mode change mid-frame has no effect
    run_frame(1, 0, 0, 1, gos, err);
    chk(gos == 2 && err == 0, "R12 mode sampled at start", gos, 2);
    cfg_no_retry = 0;
    // R7 forced collisions with loopback
    cfg_force_coll = 1; cfg_int_loop = 1;
    run_frame(0, 1, 0, 0, gos, err);
    chk(gos == 16 && err == 1, "R7 forced collisions", gos, 16);
    // R8 forced collisions ignored without loopback
    cfg_int_loop = 0;
    run_frame(0, 1, 0, 0, gos, err);
    chk(gos == 1 && err == 0, "R8 force ignored", gos, 1);
    cfg_force_coll = 0;
    // R9 gentle backoff
    mbo_set = 1; @(negedge clk); mbo_set = 0;
    chk(mod_bo_on == 1, "R9 enable set", mod_bo_on, 1);
    gentle = 1;
    for (int i = 0; i < 12; i++) begin
      run_frame(4, 0, 0, 0, gos, err);
      chk(gos == 5 && err == 0, "R9 gentle frame", gos, 5);
    end
    // R10 stop during backoff
    frame_req = 1; @(negedge clk); frame_req = 0;
    chk(tx_go == 1, "R2 go after req", tx_go, 1);
    collision = 1; @(negedge clk); collision = 0;
    stop = 1; @(negedge clk); stop = 0;
    gentle = 0;
    chk(!busy && !mod_bo_on && !done, "R10 stop abort", busy, 0);
    repeat (20) begin
      @(negedge clk);
      chk(!tx_go && !done, "R10 nothing after stop", tx_go, 0);
    end
    run_frame(2, 0, 0, 0, gos, err);
    chk(gos == 3 && err == 0, "R10 resume after stop", gos, 3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule